// File: doc/BRIEF.md
# RV32I Execute Stage with Branch Resolution

This block is the execute step of a single-cycle 32-bit integer core. It takes the fetched instruction word, that instruction's address, the two register file read values, the already sign-extended immediate and two operand-source selects from the decoder. From these it produces an ALU result, a jump-taken flag and a jump target address, all in the same cycle. There are no registers inside.

The ALU function is derived locally from the opcode, the funct3 field and instruction bit 30. The function is also brought out as a small numeric code. Each ALU operand passes through a two-way multiplexer under its select. Branch conditions compare the two register values directly, while the target comes from the ALU. That target is the address plus the immediate for branches and JAL, and register plus immediate for JALR. The result feeds memory addressing and write-back elsewhere in the core.

Top module: `exec_stage`

## Requirements
- R1: When `op1_sel` is 0 the first ALU operand is `rs1_val`; when it is 1 it is `pc`.
- R2: When `op2_sel` is 0 the second ALU operand is `rs2_val`; when it is 1 it is `imm`.
- R3: For opcode 0110011 the result follows funct3. 000 gives add, or subtract when bit 30 is set. 001 gives shift left. 010 gives signed less-than (1 or 0). 011 gives unsigned less-than. 100 gives xor. 101 gives logical right shift, or arithmetic right shift when bit 30 is set. 110 gives or. 111 gives and. Shift amounts use the low 5 bits of operand 2.
- R4: For opcode 0010011 the same funct3 mapping applies, except that funct3 000 always adds whatever bit 30 is. Bit 30 selects arithmetic right shift only for funct3 101.
- R5: For opcodes 0110111, 0010111, 0000011, 0100011, 1101111, 1100111 and 1100011 the result is operand 1 plus operand 2, modulo 2^32.
- R6: `alu_fn` carries the function code: 0 none, 1 add, 2 sub, 3 shift left, 4 signed less-than, 5 unsigned less-than, 6 or, 7 xor, 8 and, 9 logical right shift, 10 arithmetic right shift.
- R7: `jump_taken` is 0 for every opcode other than 1100011, 1101111 and 1100111.
- R8: For opcode 1100011, `jump_taken` depends on funct3. 000 means equal. 001 means not equal. 100 means signed less-than. 101 means signed greater-or-equal. 110 means unsigned less-than. 111 means unsigned greater-or-equal. Funct3 010 and 011 never jump.
- R9: For opcode 1101111, `jump_taken` is 1 and `jump_target` equals `alu_result`.
- R10: For opcode 1100111, `jump_taken` is 1 and `jump_target` is `alu_result` with bit 0 forced to 0.
- R11: For all opcodes other than 1100111, `jump_target` equals `alu_result`, whether or not a branch is taken.
- R12: An opcode outside the listed set gives `alu_fn` 0, `alu_result` 0 and `jump_taken` 0. The all-zero input word is such a case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| pc | input | 32 | Address of that instruction |
| rs1_val | input | 32 | First register read value |
| rs2_val | input | 32 | Second register read value |
| imm | input | 32 | Sign-extended immediate |
| op1_sel | input | 1 | 0: rs1_val, 1: pc |
| op2_sel | input | 1 | 0: rs2_val, 1: imm |
| alu_fn | output | 4 | Decoded ALU function code |
| alu_result | output | 32 | ALU output |
| jump_taken | output | 1 | Control transfer taken |
| jump_target | output | 32 | Address to fetch next when taken |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle its inputs are applied, with no register on the path. The bench applies a new input set just after a falling clock edge. It samples all four outputs one nanosecond later, well before the next rising edge. It then compares them with values it computes arithmetically from the requirements. The sweeps cover every funct3 and bit-30 combination for the two arithmetic opcodes, all eight branch funct3 codes, and all four select combinations over a fixed set of corner operands.

// File: rtl/exec_pkg.sv
package exec_pkg;

   localparam int unsigned ILEN     = 32;
   localparam int unsigned FN_W     = 4;

   typedef enum logic [FN_W-1:0] {
      FN_NONE = 4'd0,
      FN_ADD  = 4'd1,
      FN_SUB  = 4'd2,
      FN_SLL  = 4'd3,
      FN_SLT  = 4'd4,
      FN_SLTU = 4'd5,
      FN_OR   = 4'd6,
      FN_XOR  = 4'd7,
      FN_AND  = 4'd8,
      FN_SRL  = 4'd9,
      FN_SRA  = 4'd10
   } alu_fn_e;

   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

endpackage

// File: rtl/exec_alu_ctrl.sv
module exec_alu_ctrl
   import exec_pkg::*;
(
   input  logic [6:0] opcode,
   input  logic [2:0] funct3,
   input  logic       alt,
   output alu_fn_e    fn
);

   alu_fn_e arith_fn;

   always_comb begin
      unique case (funct3)
         3'b000:  arith_fn = (alt && opcode == OPC_REG) ? FN_SUB : FN_ADD;
         3'b001:  arith_fn = FN_SLL;
         3'b010:  arith_fn = FN_SLT;
         3'b011:  arith_fn = FN_SLTU;
         3'b100:  arith_fn = FN_XOR;
         3'b101:  arith_fn = alt ? FN_SRA : FN_SRL;
         3'b110:  arith_fn = FN_OR;
         default: arith_fn = FN_AND;
      endcase
   end

   always_comb begin
      unique case (opcode)
         OPC_REG, OPC_IMM:                       fn = arith_fn;
         OPC_LUI, OPC_AUIPC, OPC_LOAD, OPC_STORE,
         OPC_JAL, OPC_JALR, OPC_BRANCH:          fn = FN_ADD;
         default:                                fn = FN_NONE;
      endcase
   end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
   import exec_pkg::*;
#(
   parameter int unsigned XLEN = 32
)(
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  alu_fn_e         fn,
   output logic [XLEN-1:0] res
);

   localparam int unsigned SHAMT_W = $clog2(XLEN);

   logic [SHAMT_W-1:0] shamt;
   logic [XLEN-1:0]    unused_op_b_hi;

   assign shamt          = op_b[SHAMT_W-1:0];
   assign unused_op_b_hi = op_b;

   always_comb begin
      unique case (fn)
         FN_ADD:  res = op_a + op_b;
         FN_SUB:  res = op_a - op_b;
         FN_SLL:  res = op_a << shamt;
         FN_SLT:  res = {{(XLEN-1){1'b0}}, $signed(op_a) < $signed(op_b)};
         FN_SLTU: res = {{(XLEN-1){1'b0}}, op_a < op_b};
         FN_OR:   res = op_a | op_b;
         FN_XOR:  res = op_a ^ op_b;
         FN_AND:  res = op_a & op_b;
         FN_SRL:  res = op_a >> shamt;
         FN_SRA:  res = $unsigned($signed(op_a) >>> shamt);
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/exec_branch.sv
module exec_branch
   import exec_pkg::*;
#(
   parameter int unsigned XLEN = 32
)(
   input  logic [6:0]      opcode,
   input  logic [2:0]      funct3,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic [XLEN-1:0] alu_res,
   output logic            taken,
   output logic [XLEN-1:0] target
);

   logic eq, lt_s, lt_u, cond;

   assign eq   = (src_a == src_b);
   assign lt_s = ($signed(src_a) < $signed(src_b));
   assign lt_u = (src_a < src_b);

   always_comb begin
      unique case (funct3)
         3'b000:  cond = eq;
         3'b001:  cond = !eq;
         3'b100:  cond = lt_s;
         3'b101:  cond = !lt_s;
         3'b110:  cond = lt_u;
         3'b111:  cond = !lt_u;
         default: cond = 1'b0;
      endcase
   end

   always_comb begin
      unique case (opcode)
         OPC_BRANCH:        taken = cond;
         OPC_JAL, OPC_JALR: taken = 1'b1;
         default:           taken = 1'b0;
      endcase
   end

   assign target = {alu_res[XLEN-1:1], alu_res[0] & (opcode != OPC_JALR)};

endmodule

// File: rtl/exec_stage.sv
module exec_stage
   import exec_pkg::*;
#(
   parameter int unsigned XLEN = 32
)(
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] rs2_val,
   input  logic [XLEN-1:0] imm,
   input  logic            op1_sel,
   input  logic            op2_sel,
   output logic [FN_W-1:0] alu_fn,
   output logic [XLEN-1:0] alu_result,
   output logic            jump_taken,
   output logic [XLEN-1:0] jump_target
);

   generate
      if (XLEN != ILEN) begin : g_bad_xlen
         initial $fatal(1, "exec_stage: XLEN must equal the instruction width");
      end
   endgenerate

   logic [6:0]      opcode;
   logic [2:0]      funct3;
   logic            alt;
   logic [XLEN-1:0] op_a, op_b, res;
   alu_fn_e         fn;
   logic            unused_instr_bits;

   assign opcode            = instr[6:0];
   assign funct3            = instr[14:12];
   assign alt               = instr[30];
   assign unused_instr_bits = ^{instr[31], instr[29:15], instr[11:7]};

   assign op_a = op1_sel ? pc  : rs1_val;
   assign op_b = op2_sel ? imm : rs2_val;

   exec_alu_ctrl u_ctrl (
      .opcode (opcode),
      .funct3 (funct3),
      .alt    (alt),
      .fn     (fn)
   );

   exec_alu #(.XLEN(XLEN)) u_alu (
      .op_a (op_a),
      .op_b (op_b),
      .fn   (fn),
      .res  (res)
   );

   exec_branch #(.XLEN(XLEN)) u_br (
      .opcode  (opcode),
      .funct3  (funct3),
      .src_a   (rs1_val),
      .src_b   (rs2_val),
      .alu_res (res),
      .taken   (jump_taken),
      .target  (jump_target)
   );

   assign alu_fn     = fn;
   assign alu_result = res;

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk #(
   parameter int unsigned XLEN = 32
)(
   input logic [31:0]     instr,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] rs1_val,
   input logic [XLEN-1:0] rs2_val,
   input logic [XLEN-1:0] imm,
   input logic            op1_sel,
   input logic            op2_sel,
   input logic [3:0]      alu_fn,
   input logic [XLEN-1:0] alu_result,
   input logic            jump_taken,
   input logic [XLEN-1:0] jump_target
);

   logic [6:0]      opc;
   logic [XLEN-1:0] sel_a, sel_b;
   logic            known;

   assign opc   = instr[6:0];
   assign sel_a = op1_sel ? pc : rs1_val;
   assign sel_b = op2_sel ? imm : rs2_val;
   assign known = opc inside {7'b0110011, 7'b0010011, 7'b0110111, 7'b0010111,
                              7'b0000011, 7'b0100011, 7'b1101111, 7'b1100111,
                              7'b1100011};

   always_comb begin
      if (opc == 7'b1101111)
         p_jal_link_r9: assert (jump_taken && jump_target == alu_result);
      if (opc == 7'b1100111)
         p_jalr_even_r10: assert (jump_taken && !jump_target[0] &&
                                  jump_target[XLEN-1:1] == alu_result[XLEN-1:1]);
      if (known && !(opc inside {7'b1101111, 7'b1100111, 7'b1100011}))
         p_no_jump_r7: assert (!jump_taken);
      if (!known)
         p_idle_r12: assert (alu_fn == 4'd0 && alu_result == '0 && !jump_taken);
      if (opc == 7'b1100011 && instr[14:12] == 3'b000)
         p_beq_r8: assert (jump_taken == (rs1_val == rs2_val));
      if (alu_fn == 4'd1)
         p_add_r5: assert (alu_result == sel_a + sel_b);
      if (opc != 7'b1100111)
         p_target_r11: assert (jump_target == alu_result);
   end

endmodule

bind exec_stage exec_stage_chk #(.XLEN(XLEN)) u_chk (
   .instr       (instr),
   .pc          (pc),
   .rs1_val     (rs1_val),
   .rs2_val     (rs2_val),
   .imm         (imm),
   .op1_sel     (op1_sel),
   .op2_sel     (op2_sel),
   .alu_fn      (alu_fn),
   .alu_result  (alu_result),
   .jump_taken  (jump_taken),
   .jump_target (jump_target)
);

// File: tb/tb_exec_stage.sv
`timescale 1ns/1ps
module tb_exec_stage;

   logic        clk = 1'b0;
   logic [31:0] instr = '0, pc = '0, rs1_val = '0, rs2_val = '0, imm = '0;
   logic        op1_sel = 1'b0, op2_sel = 1'b0;
   logic [3:0]  alu_fn;
   logic [31:0] alu_result, jump_target;
   logic        jump_taken;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   exec_stage dut (
      .instr(instr), .pc(pc), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm),
      .op1_sel(op1_sel), .op2_sel(op2_sel), .alu_fn(alu_fn),
      .alu_result(alu_result), .jump_taken(jump_taken), .jump_target(jump_target)
   );

   // R6 code values
   localparam logic [3:0] C_NONE=0, C_ADD=1, C_SUB=2, C_SLL=3, C_SLT=4, C_SLTU=5,
                          C_OR=6, C_XOR=7, C_AND=8, C_SRL=9, C_SRA=10;

   function automatic logic [31:0] vpick(int k);
      case (k)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'hFFFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'h7FFF_FFFF;
         5: return 32'h118F_33FA;
         6: return 32'h18D4_CCE0;
         default: return 32'h0000_0025;
      endcase
   endfunction

   function automatic logic [31:0] mk(logic [6:0] op, logic [2:0] f3, logic b30);
      return {1'b0, b30, 5'd0, 5'd2, 5'd1, f3, 5'd3, op};
   endfunction

   function automatic logic [3:0] ref_fn(logic [31:0] i);
      logic [2:0] f3 = i[14:12];
      case (i[6:0])
         7'b0110011, 7'b0010011: begin
            case (f3)
               3'd0: return (i[30] && i[6:0] == 7'b0110011) ? C_SUB : C_ADD;
               3'd1: return C_SLL;
               3'd2: return C_SLT;
               3'd3: return C_SLTU;
               3'd4: return C_XOR;
               3'd5: return i[30] ? C_SRA : C_SRL;
               3'd6: return C_OR;
               default: return C_AND;
            endcase
         end
         7'b0110111, 7'b0010111, 7'b0000011, 7'b0100011,
         7'b1101111, 7'b1100111, 7'b1100011: return C_ADD;
         default: return C_NONE;
      endcase
   endfunction

   function automatic logic [31:0] ref_res(logic [3:0] f, logic [31:0] x, logic [31:0] y);
      int s = int'(y[4:0]);
      logic sx, sy;
      sx = x[31]; sy = y[31];
      case (f)
         C_ADD:  return x + y;
         C_SUB:  return x + ~y + 32'd1;
         C_SLL:  return x << s;
         C_SLT:  return (sx != sy) ? {31'd0, sx} : {31'd0, x < y};
         C_SLTU: return {31'd0, x < y};
         C_OR:   return x | y;
         C_XOR:  return x ^ y;
         C_AND:  return x & y;
         C_SRL:  return x >> s;
         C_SRA:  return (x >> s) | (sx ? ~(32'hFFFF_FFFF >> s) : 32'd0);
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic ref_taken(logic [31:0] i, logic [31:0] a, logic [31:0] b);
      logic slt = (a[31] != b[31]) ? a[31] : (a < b);
      case (i[6:0])
         7'b1101111, 7'b1100111: return 1'b1;
         7'b1100011: case (i[14:12])
            3'd0: return a == b;
            3'd1: return a != b;
            3'd4: return slt;
            3'd5: return !slt;
            3'd6: return a < b;
            3'd7: return !(a < b);
            default: return 1'b0;
         endcase
         default: return 1'b0;
      endcase
   endfunction

   task automatic run(string req, logic [31:0] i, logic [31:0] p, logic [31:0] a,
                      logic [31:0] b, logic [31:0] im, logic s1, logic s2);
      logic [3:0]  ef;
      logic [31:0] er, et;
      logic        ej;
      @(negedge clk);
      instr = i; pc = p; rs1_val = a; rs2_val = b; imm = im; op1_sel = s1; op2_sel = s2;
      #1;
      ef = ref_fn(i);
      er = ref_res(ef, s1 ? p : a, s2 ? im : b);
      ej = ref_taken(i, a, b);
      et = (i[6:0] == 7'b1100111) ? {er[31:1], 1'b0} : er;
      checks++;
      if (alu_fn !== ef || alu_result !== er || jump_taken !== ej || jump_target !== et) begin
         fails++;
         $display("FAIL %s instr=%h: fn %0d/%0d res %h/%h jmp %b/%b tgt %h/%h (actual/expected)",
                  req, i, alu_fn, ef, alu_result, er, jump_taken, ej, jump_target, et);
      end
   endtask

   task automatic lit(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, got, exp);
      end
   endtask

   initial begin
      // R12: all-zero word
      run("R12", 32'h0, 0, 0, 0, 0, 0, 0);
      lit("R12", {28'd0, alu_fn}, 32'd0);
      run("R12", 32'h0000_007F, 32'h40, 5, 6, 7, 1, 1);

      // R3, R6: register-register sweep
      for (int f = 0; f < 8; f++)
         for (int alt = 0; alt < 2; alt++)
            for (int x = 0; x < 8; x++)
               for (int y = 0; y < 8; y++)
                  run("R3", mk(7'b0110011, 3'(f), 1'(alt)), 32'h100, vpick(x), vpick(y), 32'h5, 0, 0);

      // R4: immediate sweep, bit 30 ignored for funct3 000
      for (int f = 0; f < 8; f++)
         for (int alt = 0; alt < 2; alt++)
            for (int x = 0; x < 8; x++)
               for (int y = 0; y < 8; y++)
                  run("R4", mk(7'b0010011, 3'(f), 1'(alt)), 32'h100, vpick(x), 32'h9, vpick(y), 0, 1);

      // R8, R11: every branch funct3
      for (int f = 0; f < 8; f++)
         for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++)
               run("R8", mk(7'b1100011, 3'(f), 0), 32'h1000 + 32'(x*4), vpick(x), vpick(y), 32'hFFFF_FFF0, 1, 1);

      // R1, R2, R5: all select combinations on add-class opcodes
      for (int k = 0; k < 4; k++)
         for (int x = 0; x < 8; x++) begin
            run("R1", mk(7'b0010111, 0, 0), vpick(x), vpick(7-x), vpick(x^3), vpick(x^5), k[0], k[1]);
            run("R2", mk(7'b0000011, 2, 0), vpick(x^1), vpick(x), vpick(x^2), vpick(x^4), k[0], k[1]);
            run("R5", mk(7'b0110111, 0, 0), vpick(x), vpick(x^6), vpick(x^2), vpick(x^7), k[0], k[1]);
            run("R7", mk(7'b0100011, 2, 0), vpick(x), vpick(x), vpick(x), vpick(x^1), k[0], k[1]);
         end

      // R9, R10: jumps
      for (int x = 0; x < 8; x++) begin
         run("R9",  mk(7'b1101111, 3'(x), 0), vpick(x), vpick(x^1), 0, vpick(x^2), 1, 1);
         run("R10", mk(7'b1100111, 0, 0), 32'h2000, vpick(x), 0, vpick(x^3) | 32'h1, 0, 1);
         run("R10", mk(7'b1100111, 0, 0), 32'h2000, vpick(x) | 32'h1, 0, 32'h0, 0, 1);
      end

      // worked examples
      run("R3", 32'h001101B3, 32'h0, 32'h118F33FA, 32'h18D4CCE0, 0, 0, 0);
      lit("R3", alu_result, 32'h2A6400DA);
      lit("R7", {31'd0, jump_taken}, 32'd0);
      run("R8", 32'h00208163, 32'h0, 32'd9, 32'd9, 32'd4, 1, 1);
      lit("R8", {31'd0, jump_taken}, 32'd1);
      lit("R11", jump_target, 32'd4);
      run("R9", 32'h038000EF, 32'h1014, 0, 0, 32'h38, 1, 1);
      lit("R9", jump_target, 32'h104C);
      lit("R6", {28'd0, alu_fn}, 32'd1);
      run("R5", 32'h00112023, 32'h0, 32'hFFFF_FFFC, 32'h1018, 32'h0, 0, 1);
      lit("R5", alu_result, 32'hFFFF_FFFC);
      run("R6", 32'h33336313, 32'h0, 32'h3333_0000, 0, 32'h33, 0, 1);
      lit("R6", {28'd0, alu_fn}, 32'd6);
      lit("R6", alu_result, 32'h3333_0033);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule